// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of an SDRAM device from the moment reset is released until the device is ready for normal traffic. It first holds the bus in a no-operation state for a settle period counted in clocks. It then closes every bank with one precharge and issues two auto-refresh commands, each spaced by its recovery time. Last, it writes the mode register with a word assembled from the block's parameters. Once the mode-register delay has run out it raises a done flag, and it keeps the bus quiet from then on.

All waits are parameters given in clocks, so one design serves any clock rate. At 100 MHz the defaults give 10,000 settle clocks, a 2-clock precharge recovery, a 7-clock refresh recovery and a 2-clock mode-register delay. The mode word is built from four parameters: burst length in beats (1, 2, 4, 8, or 0 for a full page), sequential or interleaved ordering, read latency (2 or 3), and single-location writes. A reserved combination stops elaboration with an error. Clock enable stays high for the whole sequence. The bank and address pins read zero in every cycle where they carry no meaning.

A controller with a phase register and one shared counter produces a small set of one-cycle strobes. A registered pin stage turns these strobes into commands, so every output comes from a flop.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is low and in every no-operation cycle, the pins read {memCsN,memRasN,memCasN,memWeN} = 0111, memBank = 0 and memAddr = 0. memCke is 1 in every cycle and initDone is 0 during reset.
- R2: The first command, precharge-all (command code 0010, memAddr = 0x400 so that bit 10 alone is set, memBank = 0), appears in the clock after exactly SETTLE_CYCLES no-operation clocks that follow reset release. If the first clock edge after release is counted as clock 1, precharge-all is on the pins after clock SETTLE_CYCLES+1.
- R3: The first auto-refresh (command code 0001, memAddr = 0, memBank = 0) appears exactly PRECH_GAP clocks after the precharge.
- R4: The second auto-refresh appears exactly REFRESH_GAP clocks after the first. The mode-register load (command code 0000) appears exactly REFRESH_GAP clocks after the second refresh. Only no-operation cycles lie between these commands.
- R5: During the mode-register load, memAddr[2:0] holds the burst-length code, memAddr[3] the ordering (0 sequential, 1 interleaved), memAddr[6:4] the latency code and memAddr[9] the write mode (1 = single-location writes). memAddr[8:7], memAddr[11:10] and memBank are all 0.
- R6: The encodings are as follows. Burst length: 1→000, 2→001, 4→010, 8→011, full page→111. Latency: 2→010, 3→011. Example words: 8 beats interleaved, latency 3, burst writes → 0x03B. Full page sequential, latency 2, single writes → 0x227. 2 beats sequential, latency 2, burst writes → 0x021.
- R7: initDone rises exactly MRD_GAP clocks after the mode-register load, and not before. It stays high until the next reset, and no command other than no-operation appears after the mode-register load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts the sequence when released |
| memCke | output | 1 | Clock enable to the memory, held high |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBank | output | BANK_W | Bank select |
| memAddr | output | ADDR_W | Address / mode word |
| initDone | output | 1 | High once the sequence is complete |

## Verification
The bench runs three parameter sets side by side. Among them they include a gap of one clock, where the wait phase must vanish entirely, and a full-page burst whose length code is 111. A counter that loads its limit off by one shows up as a command landing one clock early or late against the precomputed timeline. A swapped field or latency code shows up as a wrong mode word. A done flag tied to the load itself rather than to the elapsed delay rises too soon, and a done that is not held drops during the trailing idle window.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueLmr;
    logic finished;
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  function automatic logic [2:0] burstLenCode(input int beats);
    case (beats)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;  // 0 selects a full-page burst
    endcase
  endfunction

  function automatic bit cfgLegal(input int beats, input bit interleave,
                                  input int casLat, input int addrW);
    bit lenOk;
    lenOk = (beats == 1) || (beats == 2) || (beats == 4) || (beats == 8) ||
            ((beats == 0) && !interleave);
    return lenOk && ((casLat == 2) || (casLat == 3)) && (addrW >= 12);
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int SETTLE_CYCLES = 10000,
  parameter int PRECH_GAP     = 2,
  parameter int REFRESH_GAP   = 7,
  parameter int MRD_GAP       = 2
) (
  input  logic       clk,
  input  logic       rstN,
  output seqStrobe_t strobe
);

  localparam int MAX_A    = (SETTLE_CYCLES > PRECH_GAP) ? SETTLE_CYCLES : PRECH_GAP;
  localparam int MAX_B    = (REFRESH_GAP > MRD_GAP) ? REFRESH_GAP : MRD_GAP;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  typedef enum logic [2:0] {
    PH_SETTLE, PH_PRE, PH_REF1, PH_REF2, PH_LMR, PH_DONE
  } phase_t;

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // Each phase lasts exactly its limit+1 clocks; the command strobe fires in its first clock.
  always_comb begin
    limit     = '0;
    phaseNext = phase;
    case (phase)
      PH_SETTLE: begin limit = CNT_W'(SETTLE_CYCLES - 1); phaseNext = PH_PRE;  end
      PH_PRE:    begin limit = CNT_W'(PRECH_GAP - 1);     phaseNext = PH_REF1; end
      PH_REF1:   begin limit = CNT_W'(REFRESH_GAP - 1);   phaseNext = PH_REF2; end
      PH_REF2:   begin limit = CNT_W'(REFRESH_GAP - 1);   phaseNext = PH_LMR;  end
      PH_LMR:    begin limit = CNT_W'(MRD_GAP - 1);       phaseNext = PH_DONE; end
      default:   begin limit = '0;                        phaseNext = PH_DONE; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_SETTLE;
      cnt   <= '0;
    end else if (phase != PH_DONE) begin
      if (cnt == limit) begin
        phase <= phaseNext;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic atStart;
  assign atStart = (cnt == '0);

  always_comb begin
    strobe.issuePre = (phase == PH_PRE) && atStart;
    strobe.issueRef = ((phase == PH_REF1) || (phase == PH_REF2)) && atStart;
    strobe.issueLmr = (phase == PH_LMR) && atStart;
    strobe.finished = (phase == PH_DONE);
  end

endmodule

// File: rtl/sdram_init_cmd.sv
module sdram_init_cmd
  import sdram_init_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                BANK_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  localparam int ALL_BANKS_BIT = 10;

  logic [3:0]        cmdQ, cmdD;
  logic [ADDR_W-1:0] addrQ, addrD;
  logic              doneQ;

  always_comb begin
    cmdD  = CMD_NOP;
    addrD = '0;
    if (strobe.issuePre) begin
      cmdD                 = CMD_PRE;
      addrD[ALL_BANKS_BIT] = 1'b1;
    end else if (strobe.issueRef) begin
      cmdD = CMD_REF;
    end else if (strobe.issueLmr) begin
      cmdD  = CMD_LMR;
      addrD = MODE_WORD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      doneQ <= 1'b0;
    end else begin
      cmdQ  <= cmdD;
      addrQ <= addrD;
      doneQ <= strobe.finished;
    end
  end

  assign memCke   = 1'b1;
  assign {memCsN, memRasN, memCasN, memWeN} = cmdQ;
  assign memBank  = '0;
  assign memAddr  = addrQ;
  assign initDone = doneQ;

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int SETTLE_CYCLES    = 10000,
  parameter int PRECH_GAP        = 2,
  parameter int REFRESH_GAP      = 7,
  parameter int MRD_GAP          = 2,
  parameter int BURST_BEATS      = 8,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int CAS_LATENCY      = 3,
  parameter bit WRITE_SINGLE     = 1'b0,
  parameter int ADDR_W           = 12,
  parameter int BANK_W           = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BANK_W-1:0] memBank,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initDone
);

  localparam logic [2:0]        CAS_CODE = (CAS_LATENCY == 3) ? 3'b011 : 3'b010;
  localparam logic [2:0]        LEN_CODE = burstLenCode(BURST_BEATS);
  localparam logic [11:0]       MODE12   = {2'b00, WRITE_SINGLE, 2'b00, CAS_CODE,
                                            BURST_INTERLEAVE, LEN_CODE};
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(MODE12);

  if (!cfgLegal(BURST_BEATS, BURST_INTERLEAVE, CAS_LATENCY, ADDR_W)) begin : g_badCfg
    $error("sdram_powerup_seq: reserved burst length, ordering or latency selected");
  end

  seqStrobe_t strobe;

  sdram_init_ctrl #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .PRECH_GAP    (PRECH_GAP),
    .REFRESH_GAP  (REFRESH_GAP),
    .MRD_GAP      (MRD_GAP)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  sdram_init_cmd #(
    .ADDR_W   (ADDR_W),
    .BANK_W   (BANK_W),
    .MODE_WORD(MODE_WORD)
  ) u_cmd (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .memCke  (memCke),
    .memCsN  (memCsN),
    .memRasN (memRasN),
    .memCasN (memCasN),
    .memWeN  (memWeN),
    .memBank (memBank),
    .memAddr (memAddr),
    .initDone(initDone)
  );

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int SETTLE_CYCLES = 10000,
  parameter int PRECH_GAP     = 2,
  parameter int REFRESH_GAP   = 7,
  parameter int MRD_GAP       = 2,
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              memCke,
  input logic              memCsN,
  input logic              memRasN,
  input logic              memCasN,
  input logic              memWeN,
  input logic [BANK_W-1:0] memBank,
  input logic [ADDR_W-1:0] memAddr,
  input logic              initDone
);

  localparam int SAT = 32'h7fff_ffff;

  logic [3:0] cmd;
  logic [3:0] lastCmd;
  int         sinceCmd;
  int         nopRun;

  assign cmd = {memCsN, memRasN, memCasN, memWeN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCmd  <= CMD_NOP;
      sinceCmd <= 0;
      nopRun   <= 0;
    end else begin
      if (cmd != CMD_NOP) begin
        lastCmd  <= cmd;
        sinceCmd <= 1;
      end else if (sinceCmd != SAT) begin
        sinceCmd <= sinceCmd + 1;
      end
      if (cmd == CMD_NOP && lastCmd == CMD_NOP && nopRun != SAT) nopRun <= nopRun + 1;
    end
  end

  AST_CKE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    memCke) else $error("cke low");  // R1
  AST_IDLE_PINS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP) |-> (memBank == '0 && memAddr == '0)) else $error("idle pins");  // R1
  AST_SETTLE_MET: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRE) |-> (lastCmd == CMD_NOP && nopRun >= SETTLE_CYCLES)) else $error("settle");  // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PRE) |-> (memAddr[10] && memBank == '0)) else $error("pre addr");  // R2
  AST_REF_AFTER_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF && lastCmd == CMD_PRE) |-> (sinceCmd == PRECH_GAP)) else $error("rp gap");  // R3
  AST_REF_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_REF && lastCmd == CMD_REF) |-> (sinceCmd == REFRESH_GAP)) else $error("rfc gap");  // R4
  AST_LMR_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_LMR) |-> (lastCmd == CMD_REF && sinceCmd == REFRESH_GAP)) else $error("lmr gap");  // R4
  AST_LMR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_LMR) |-> (memAddr[11:10] == 2'b00 && memAddr[8:7] == 2'b00 && memBank == '0))
    else $error("mode word reserved bits");  // R5
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> (lastCmd == CMD_LMR && sinceCmd == MRD_GAP)) else $error("done timing");  // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone) else $error("done dropped");  // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (cmd == CMD_NOP)) else $error("command after done");  // R7

endmodule

bind sdram_powerup_seq sdram_init_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .PRECH_GAP    (PRECH_GAP),
  .REFRESH_GAP  (REFRESH_GAP),
  .MRD_GAP      (MRD_GAP),
  .ADDR_W       (ADDR_W),
  .BANK_W       (BANK_W)
) u_initChk (
  .clk     (clk),
  .rstN    (rstN),
  .memCke  (memCke),
  .memCsN  (memCsN),
  .memRasN (memRasN),
  .memCasN (memCasN),
  .memWeN  (memWeN),
  .memBank (memBank),
  .memAddr (memAddr),
  .initDone(initDone)
);

// File: tb/test_sdram_powerup_seq.sv
module seq_monitor #(
  parameter string NAME = "dut"
) (
  input logic        clk,
  input logic        rstN,
  input logic        cke,
  input logic        csN,
  input logic        rasN,
  input logic        casN,
  input logic        weN,
  input logic [1:0]  bank,
  input logic [11:0] addr,
  input logic        done
);

  typedef struct {
    int          at;
    logic [3:0]  cmd;
    logic [11:0] addr;
    string       req;
  } item_t;

  item_t      expQ[$];
  item_t      it;
  logic [3:0] cmd;
  int         checks   = 0;
  int         errors   = 0;
  int         idx      = 0;
  int         idleBad  = 0;
  int         doneAt   = -1;
  bit         doneSeen = 1'b0;

  // Driver side: expected command timeline in clocks after reset release.
  task automatic planSequence(input int settle, input int rp, input int rfc,
                              input int mrd, input logic [11:0] mode);
    int t;
    t = settle + 1;
    expQ.push_back('{t, 4'b0010, 12'h400, "R2"});
    t = t + rp;
    expQ.push_back('{t, 4'b0001, 12'h000, "R3"});
    t = t + rfc;
    expQ.push_back('{t, 4'b0001, 12'h000, "R4"});
    t = t + rfc;
    expQ.push_back('{t, 4'b0000, mode, "R4 R5 R6"});
    doneAt = t + mrd;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      idx = idx + 1;
      cmd = {csN, rasN, casN, weN};
      if (!cke || (cmd == 4'b0111 && (bank != 2'b00 || addr != 12'h000)))
        idleBad = idleBad + 1;
      if (cmd != 4'b0111) begin
        checks = checks + 1;
        if (expQ.size() == 0) begin
          errors = errors + 1;
          $display("FAIL R7 %s: unexpected command at clock %0d actual cmd %b expected 0111",
                   NAME, idx, cmd);
        end else begin
          it = expQ.pop_front();
          if (idx != it.at || cmd != it.cmd || addr != it.addr || bank != 2'b00) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual clock %0d cmd %b addr %h bank %0d expected clock %0d cmd %b addr %h bank 0",
                     it.req, NAME, idx, cmd, addr, bank, it.at, it.cmd, it.addr);
          end
        end
      end
      if (done && !doneSeen) begin
        doneSeen = 1'b1;
        checks   = checks + 1;
        if (idx != doneAt || expQ.size() != 0) begin
          errors = errors + 1;
          $display("FAIL R7 %s: done rose at clock %0d expected %0d (pending %0d)",
                   NAME, idx, doneAt, expQ.size());
        end
      end else if (!done && doneSeen) begin
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL R7 %s: done dropped at clock %0d actual 0 expected 1", NAME, idx);
      end
    end
  end

  task automatic finalCheck();
    checks = checks + 1;
    if (idleBad != 0) begin
      errors = errors + 1;
      $display("FAIL R1 %s: idle cycles with nonzero pins or low cke actual %0d expected 0",
               NAME, idleBad);
    end
    checks = checks + 1;
    if (!doneSeen || expQ.size() != 0) begin
      errors = errors + 1;
      $display("FAIL R7 %s: sequence incomplete actual done %0d pending %0d expected done 1 pending 0",
               NAME, doneSeen, expQ.size());
    end
  endtask

endmodule

module test_sdram_powerup_seq;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int  checks   = 0;
  int  errors   = 0;
  bit  finished = 1'b0;

  logic        aCke, aCs, aRas, aCas, aWe, aDone;
  logic [1:0]  aBank;
  logic [11:0] aAddr;
  logic        bCke, bCs, bRas, bCas, bWe, bDone;
  logic [1:0]  bBank;
  logic [11:0] bAddr;
  logic        cCke, cCs, cRas, cCas, cWe, cDone;
  logic [1:0]  cBank;
  logic [11:0] cAddr;

  // Config A: default timing, 8 beats interleaved, latency 3 -> 0x03B
  sdram_powerup_seq #(
    .BURST_BEATS(8), .BURST_INTERLEAVE(1'b1), .CAS_LATENCY(3), .WRITE_SINGLE(1'b0)
  ) i_sdram_powerup_seq (
    .clk(clk), .rstN(rstN), .memCke(aCke), .memCsN(aCs), .memRasN(aRas),
    .memCasN(aCas), .memWeN(aWe), .memBank(aBank), .memAddr(aAddr), .initDone(aDone)
  );

  // Config B: one-clock gaps, full page, latency 2, single writes -> 0x227
  sdram_powerup_seq #(
    .SETTLE_CYCLES(20), .PRECH_GAP(1), .REFRESH_GAP(3), .MRD_GAP(1),
    .BURST_BEATS(0), .BURST_INTERLEAVE(1'b0), .CAS_LATENCY(2), .WRITE_SINGLE(1'b1)
  ) i_sdram_powerup_seq_b (
    .clk(clk), .rstN(rstN), .memCke(bCke), .memCsN(bCs), .memRasN(bRas),
    .memCasN(bCas), .memWeN(bWe), .memBank(bBank), .memAddr(bAddr), .initDone(bDone)
  );

  // Config C: 2 beats sequential, latency 2 -> 0x021
  sdram_powerup_seq #(
    .SETTLE_CYCLES(5), .PRECH_GAP(3), .REFRESH_GAP(4), .MRD_GAP(3),
    .BURST_BEATS(2), .BURST_INTERLEAVE(1'b0), .CAS_LATENCY(2), .WRITE_SINGLE(1'b0)
  ) i_sdram_powerup_seq_c (
    .clk(clk), .rstN(rstN), .memCke(cCke), .memCsN(cCs), .memRasN(cRas),
    .memCasN(cCas), .memWeN(cWe), .memBank(cBank), .memAddr(cAddr), .initDone(cDone)
  );

  seq_monitor #(.NAME("cfgA")) monA (.clk(clk), .rstN(rstN), .cke(aCke), .csN(aCs),
    .rasN(aRas), .casN(aCas), .weN(aWe), .bank(aBank), .addr(aAddr), .done(aDone));
  seq_monitor #(.NAME("cfgB")) monB (.clk(clk), .rstN(rstN), .cke(bCke), .csN(bCs),
    .rasN(bRas), .casN(bCas), .weN(bWe), .bank(bBank), .addr(bAddr), .done(bDone));
  seq_monitor #(.NAME("cfgC")) monC (.clk(clk), .rstN(rstN), .cke(cCke), .csN(cCs),
    .rasN(cRas), .casN(cCas), .weN(cWe), .bank(cBank), .addr(cAddr), .done(cDone));

  task automatic checkResetPins(input string name, input logic cke, input logic [3:0] cmd,
                                input logic [1:0] bank, input logic [11:0] addr,
                                input logic done);
    checks = checks + 1;
    if (!cke || cmd != 4'b0111 || bank != 2'b00 || addr != 12'h000 || done) begin
      errors = errors + 1;
      $display("FAIL R1 %s reset: actual cke %b cmd %b bank %0d addr %h done %b expected cke 1 cmd 0111 bank 0 addr 000 done 0",
               name, cke, cmd, bank, addr, done);
    end
  endtask

  task automatic summary();
    checks = checks + monA.checks + monB.checks + monC.checks;
    errors = errors + monA.errors + monB.errors + monC.errors;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    monA.planSequence(10000, 2, 7, 2, 12'h03B);  // R5 R6
    monB.planSequence(20, 1, 3, 1, 12'h227);     // R6 full page, single writes
    monC.planSequence(5, 3, 4, 3, 12'h021);      // R6 two beats
    repeat (3) @(negedge clk);
    checkResetPins("cfgA", aCke, {aCs, aRas, aCas, aWe}, aBank, aAddr, aDone);  // R1
    checkResetPins("cfgB", bCke, {bCs, bRas, bCas, bWe}, bBank, bAddr, bDone);  // R1
    checkResetPins("cfgC", cCke, {cCs, cRas, cCas, cWe}, cBank, cAddr, cDone);  // R1
    rstN <= 1'b1;
    wait (monA.doneSeen && monB.doneSeen && monC.doneSeen);
    repeat (40) @(negedge clk);  // R7 done held, bus quiet
    monA.finalCheck();
    monB.finalCheck();
    monC.finalCheck();
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors = errors + 1;
      $display("FAIL R7 watchdog: actual no completion expected done on all configs");
      monA.finalCheck();
      monB.finalCheck();
      monC.finalCheck();
      summary();
    end
  end

endmodule